// File: doc/BRIEF.md
# Timestamping Address-Event Monitor

This block taps the completed address-event transactions leaving an input arbiter and turns each accepted event into a short record in an 18-bit-wide event FIFO. Every FIFO word has a 2-bit type tag above a 16-bit payload, so a reader that loses its place can find the start of the next record. A record is the event address alone, or the address followed by a 32-bit timestamp split into a high word and a low word.

The timestamp comes from a 32-bit time counter inside the block. The counter advances once per tick, and the tick period is chosen from four values. The counter has an active-low run input and an active-low synchronous clear. Acquisition can be turned off as a whole, and any of four sender channels can be ignored through a mask. The channel is taken from the top address bits according to the arbiter sender mode. The block only sees the FIFO through its write port and its occupancy level. It writes a record only when the whole record fits. A lost event sets a sticky overflow flag, and a FIFO that reaches its depth sets a sticky full flag.

Top module: `aem_monitor`

## Requirements
- R1: Each FIFO word is {tag[1:0], payload[15:0]}. Tag 2'b00 carries the event address, 2'b01 the upper 16 timestamp bits and 2'b10 the lower 16 timestamp bits. The block never writes tag 2'b11.
- R2: With `ts_dis`=0, an accepted event produces three words on consecutive cycles in the order address, high, low. The address word is presented in the cycle after the edge that samples `ev_valid`.
- R3: With `ts_dis`=1, an accepted event produces only its address word. Such events can be accepted on every cycle.
- R4: With `mon_dis`=1 no event is accepted. The channel is 0 when `arb_mode`=2'b00, `{1'b0,ev_addr[15]}` when `arb_mode`=2'b01, and `ev_addr[15:14]` otherwise. An event whose channel has its `ch_mask` bit at 1 is ignored and does not set any flag.
- R5: Both timestamp words of a record hold the value `time_now` had in the cycle `ev_valid` was high.
- R6: While `tc_run_n`=0, `time_now` rises by exactly one every P cycles, where P is `CYC_PER_US` times 1, 10, 50 or 100 for `tick_sel` 2'b00, 2'b01, 2'b10 or 2'b11. While `tc_run_n`=1 it holds its value.
- R7: `tc_clr_n`=0 at a clock edge sets `time_now` to 0 and restarts the tick period. Clear takes priority over counting.
- R8: An event is written only if the free space (depth minus `fifo_level` minus any word being presented) covers the whole record. Otherwise the event is dropped and `ovf_flag` is set, so no partial record is ever written.
- R9: An event that arrives while the words of an earlier record are still being presented is dropped and sets `ovf_flag`.
- R10: `half_flag` shows `fifo_level` >= depth/2 one cycle late. `full_irq` is set when `fifo_level` equals the depth. Both `full_irq` and `ovf_flag` stay set until an `irq_clr` cycle in which no new set condition occurs.
- R11: During reset, `fifo_wr`, `time_now` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_valid | input | 1 | One-cycle strobe of a completed transaction |
| ev_addr | input | 16 | Address of the transaction |
| arb_mode | input | 2 | Sender mode: 00 one, 01 two, 1x four senders |
| mon_dis | input | 1 | 1 stops acquisition |
| ch_mask | input | 4 | 1 ignores events from that channel |
| ts_dis | input | 1 | 1 writes address words only |
| tick_sel | input | 2 | Tick period select |
| tc_run_n | input | 1 | Active-low counter run |
| tc_clr_n | input | 1 | Active-low synchronous counter clear |
| fifo_level | input | LVL_W | Current FIFO occupancy |
| irq_clr | input | 1 | Clears the sticky flags |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_wdata | output | 18 | Tagged FIFO word |
| time_now | output | 32 | Time counter value |
| half_flag | output | 1 | FIFO at least half full |
| full_irq | output | 1 | Sticky FIFO-full flag |
| ovf_flag | output | 1 | Sticky lost-event flag |

## Verification
The address word of an accepted event is due one cycle after the edge that samples `ev_valid`. The two timestamp words follow on the next two cycles. The flags follow one edge after the level or the drop that causes them, and `time_now` changes at the edge where a tick completes. The bench runs a behavioural model that reads the same inputs at each rising edge and keeps pending words in a queue. It compares the strobe, the word, the time and the flags with that model at every falling edge, so each result is checked in the first cycle it is due. Directed phase counts of written words then confirm the filtering, dropping and FIFO-full cases.

// File: rtl/aem_pkg.sv
package aem_pkg;
  localparam int TAG_W  = 2;
  localparam int PAY_W  = 16;
  localparam int WORD_W = TAG_W + PAY_W;
  localparam int TS_W   = 2 * PAY_W;
  localparam int NCH    = 4;

  typedef enum logic [TAG_W-1:0] {
    TAG_ADDR  = 2'b00,
    TAG_TS_HI = 2'b01,
    TAG_TS_LO = 2'b10,
    TAG_CTRL  = 2'b11
  } word_tag_e;

  typedef struct packed {
    word_tag_e          tag;
    logic [PAY_W-1:0]   payload;
  } mon_word_t;

  // Tick period in clock cycles for a period select code.
  function automatic int unsigned tick_period(logic [1:0] sel, int unsigned cyc_per_us);
    case (sel)
      2'b00:   return cyc_per_us;
      2'b01:   return cyc_per_us * 10;
      2'b10:   return cyc_per_us * 50;
      default: return cyc_per_us * 100;
    endcase
  endfunction

  // Sender channel carried by an address in a given arbiter mode.
  function automatic logic [1:0] chan_of(logic [1:0] mode, logic [PAY_W-1:0] addr);
    case (mode)
      2'b00:   return 2'd0;
      2'b01:   return {1'b0, addr[PAY_W-1]};
      default: return addr[PAY_W-1:PAY_W-2];
    endcase
  endfunction

  function automatic int unsigned words_per_event(logic ts_off);
    return ts_off ? 32'd1 : 32'd3;
  endfunction

  // True when a record of 'need' words fits beside the stored and in-flight words.
  function automatic logic has_room(int unsigned depth, int unsigned level,
                                    logic inflight, int unsigned need);
    return (level + 32'(inflight) + need) <= depth;
  endfunction
endpackage

// File: rtl/aem_tick_gen.sv
module aem_tick_gen
  import aem_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_n,
  input  logic       clr_n,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int unsigned MAX_PERIOD = CYC_PER_US * 100;
  localparam int          PRE_W      = $clog2(MAX_PERIOD + 1);

  logic [PRE_W-1:0] pre_q;
  int unsigned      period;
  logic             wrap;

  always_comb begin
    period = tick_period(sel, CYC_PER_US);
    // A period shortened mid-count wraps at once.
    wrap   = (32'(pre_q) + 32'd1) >= period;
  end

  assign tick = ~run_n & clr_n & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (!clr_n) pre_q <= '0;
    else if (!run_n) pre_q <= wrap ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/aem_time_ctr.sv
module aem_time_ctr
  import aem_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_n,
  input  logic            tick,
  output logic [TS_W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (!clr_n) value <= '0;
    else if (tick)   value <= value + 1'b1;
  end
endmodule

// File: rtl/aem_chan_filter.sv
module aem_chan_filter
  import aem_pkg::*;
(
  input  logic             ev_valid,
  input  logic [PAY_W-1:0] ev_addr,
  input  logic [1:0]       arb_mode,
  input  logic             mon_dis,
  input  logic [NCH-1:0]   ch_mask,
  output logic             hit
);
  logic [1:0]     chan;
  logic [NCH-1:0] pass;

  assign chan = chan_of(arb_mode, ev_addr);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign pass[g] = (chan == 2'(g)) & ~ch_mask[g];
  end

  assign hit = ev_valid & ~mon_dis & (|pass);
endmodule

// File: rtl/aem_record_writer.sv
module aem_record_writer
  import aem_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int          LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [PAY_W-1:0]  ev_addr,
  input  logic              ts_off,
  input  logic [TS_W-1:0]   time_now,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              fifo_wr,
  output logic [WORD_W-1:0] fifo_wdata,
  output logic              accept,
  output logic              drop
);
  logic [1:0]      rem_q;   // timestamp words still to present
  logic [TS_W-1:0] ts_q;
  mon_word_t       word_q;
  logic            wr_q;
  logic            busy, room;
  int unsigned     need;

  always_comb begin
    need   = words_per_event(ts_off);
    room   = has_room(FIFO_DEPTH, 32'(fifo_level), wr_q, need);
    busy   = (rem_q != 2'd0);
    accept = hit & ~busy & room;
    drop   = hit & ~accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      rem_q  <= 2'd0;
      ts_q   <= '0;
      word_q <= '{tag: TAG_ADDR, payload: '0};
    end else if (accept) begin
      wr_q   <= 1'b1;
      ts_q   <= time_now;
      word_q <= '{tag: TAG_ADDR, payload: ev_addr};
      rem_q  <= ts_off ? 2'd0 : 2'd2;
    end else if (rem_q == 2'd2) begin
      wr_q   <= 1'b1;
      word_q <= '{tag: TAG_TS_HI, payload: ts_q[TS_W-1:PAY_W]};
      rem_q  <= 2'd1;
    end else if (rem_q == 2'd1) begin
      wr_q   <= 1'b1;
      word_q <= '{tag: TAG_TS_LO, payload: ts_q[PAY_W-1:0]};
      rem_q  <= 2'd0;
    end else begin
      wr_q   <= 1'b0;
    end
  end

  assign fifo_wr    = wr_q;
  assign fifo_wdata = word_q;
endmodule

// File: rtl/aem_flags.sv
module aem_flags #(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int          LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             drop,
  input  logic             irq_clr,
  output logic             half_flag,
  output logic             full_irq,
  output logic             ovf_flag
);
  localparam int unsigned HALF = FIFO_DEPTH / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_flag <= 1'b0;
      full_irq  <= 1'b0;
      ovf_flag  <= 1'b0;
    end else begin
      half_flag <= 32'(fifo_level) >= HALF;
      if (32'(fifo_level) >= FIFO_DEPTH) full_irq <= 1'b1;
      else if (irq_clr)                  full_irq <= 1'b0;
      if (drop)         ovf_flag <= 1'b1;
      else if (irq_clr) ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/aem_monitor.sv
module aem_monitor
  import aem_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int          LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [15:0]       ev_addr,
  input  logic [1:0]        arb_mode,
  input  logic              mon_dis,
  input  logic [3:0]        ch_mask,
  input  logic              ts_dis,
  input  logic [1:0]        tick_sel,
  input  logic              tc_run_n,
  input  logic              tc_clr_n,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              irq_clr,
  output logic              fifo_wr,
  output logic [17:0]       fifo_wdata,
  output logic [31:0]       time_now,
  output logic              half_flag,
  output logic              full_irq,
  output logic              ovf_flag
);
  // Internal events, named for the checker.
  logic tick;
  logic ev_hit;
  logic ev_accept;
  logic ev_drop;

  aem_tick_gen #(.CYC_PER_US(CYC_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_n(tc_run_n), .clr_n(tc_clr_n),
    .sel(tick_sel), .tick(tick)
  );

  aem_time_ctr u_time (
    .clk(clk), .rst_n(rst_n), .clr_n(tc_clr_n), .tick(tick), .value(time_now)
  );

  aem_chan_filter u_filt (
    .ev_valid(ev_valid), .ev_addr(ev_addr), .arb_mode(arb_mode),
    .mon_dis(mon_dis), .ch_mask(ch_mask), .hit(ev_hit)
  );

  aem_record_writer #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .hit(ev_hit), .ev_addr(ev_addr),
    .ts_off(ts_dis), .time_now(time_now), .fifo_level(fifo_level),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .accept(ev_accept), .drop(ev_drop)
  );

  aem_flags #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .drop(ev_drop),
    .irq_clr(irq_clr), .half_flag(half_flag), .full_irq(full_irq),
    .ovf_flag(ovf_flag)
  );
endmodule

// File: rtl/aem_monitor_chk.sv
module aem_monitor_chk #(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int          LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             mon_dis,
  input logic             tc_clr_n,
  input logic             tc_run_n,
  input logic [LVL_W-1:0] fifo_level,
  input logic             irq_clr,
  input logic             fifo_wr,
  input logic [17:0]      fifo_wdata,
  input logic [31:0]      time_now,
  input logic             full_irq,
  input logic             ovf_flag,
  input logic             tick,
  input logic             ev_drop
);
  logic [1:0] tag;
  assign tag = fifo_wdata[17:16];

  a_r1_no_ctrl_tag: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> tag != 2'b11);

  a_r2_hi_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && tag == 2'b01) |-> $past(fifo_wr && fifo_wdata[17:16] == 2'b00));

  a_r2_lo_follows_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && tag == 2'b01) |=> (fifo_wr && tag == 2'b10));

  a_r4_addr_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && tag == 2'b00) |-> $past(ev_valid && !mon_dis));

  a_r6_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_run_n && tc_clr_n) |=> $stable(time_now));

  a_r6_tick_steps_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tc_clr_n) |=> time_now == $past(time_now) + 32'd1);

  a_r7_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !tc_clr_n |=> time_now == 32'd0);

  a_r8_never_past_depth: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> 32'(fifo_level) < FIFO_DEPTH);

  a_r8_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> ovf_flag);

  a_r10_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (full_irq && !irq_clr) |=> full_irq);
endmodule

bind aem_monitor aem_monitor_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .mon_dis(mon_dis),
  .tc_clr_n(tc_clr_n), .tc_run_n(tc_run_n), .fifo_level(fifo_level),
  .irq_clr(irq_clr), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
  .time_now(time_now), .full_irq(full_irq), .ovf_flag(ovf_flag),
  .tick(tick), .ev_drop(ev_drop)
);

// File: tb/aem_monitor_tb.sv
module aem_monitor_tb;
  localparam int CYC   = 1;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, ev_valid = 1'b0, mon_dis = 1'b0, ts_dis = 1'b0;
  logic tc_run_n = 1'b1, tc_clr_n = 1'b1, irq_clr = 1'b0, pop = 1'b1;
  logic [15:0] ev_addr = '0;
  logic [1:0]  arb_mode = 2'b10, tick_sel = 2'b01;
  logic [3:0]  ch_mask = '0;
  logic [LVL_W-1:0] fifo_level;
  logic fifo_wr, half_flag, full_irq, ovf_flag;
  logic [17:0] fifo_wdata;
  logic [31:0] time_now;

  aem_monitor #(.CYC_PER_US(CYC), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_addr(ev_addr),
    .arb_mode(arb_mode), .mon_dis(mon_dis), .ch_mask(ch_mask), .ts_dis(ts_dis),
    .tick_sel(tick_sel), .tc_run_n(tc_run_n), .tc_clr_n(tc_clr_n),
    .fifo_level(fifo_level), .irq_clr(irq_clr), .fifo_wr(fifo_wr),
    .fifo_wdata(fifo_wdata), .time_now(time_now), .half_flag(half_flag),
    .full_irq(full_irq), .ovf_flag(ovf_flag)
  );

  int checks = 0, errors = 0, wcnt = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // FIFO occupancy as seen by the block.
  always @(posedge clk) begin
    if (!rst_n) fifo_level <= '0;
    else fifo_level <= LVL_W'(int'(fifo_level) + (fifo_wr ? 1 : 0)
                              - ((pop && fifo_level != 0) ? 1 : 0));
    if (rst_n && fifo_wr) wcnt++;
  end

  // Behavioural reference model.
  int unsigned m_t, m_pre;
  logic [17:0] m_q[$];
  bit          m_wr, m_half, m_full, m_ovf;
  logic [17:0] m_word;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_t = 0; m_pre = 0; m_q.delete(); m_wr = 0; m_word = '0;
      m_half = 0; m_full = 0; m_ovf = 0;
    end else begin
      int unsigned per;
      int ch, need, freew;
      bit want, acc;
      per = (tick_sel == 2'd0) ? CYC : (tick_sel == 2'd1) ? 10*CYC :
            (tick_sel == 2'd2) ? 50*CYC : 100*CYC;
      ch = (arb_mode == 2'd0) ? 0 : (arb_mode == 2'd1) ? int'(ev_addr[15])
                                                        : int'(ev_addr[15:14]);
      want  = ev_valid && !mon_dis && !ch_mask[ch];
      need  = ts_dis ? 1 : 3;
      freew = DEPTH - int'(fifo_level) - (m_wr ? 1 : 0);
      acc   = want && m_q.size() == 0 && freew >= need;
      if (acc) begin
        m_q.push_back({2'b00, ev_addr});
        if (!ts_dis) begin
          m_q.push_back({2'b01, m_t[31:16]});
          m_q.push_back({2'b10, m_t[15:0]});
        end
      end
      if (m_q.size() > 0) begin m_wr = 1; m_word = m_q.pop_front(); end
      else m_wr = 0;
      if (want && !acc) m_ovf = 1; else if (irq_clr) m_ovf = 0;
      if (int'(fifo_level) >= DEPTH) m_full = 1; else if (irq_clr) m_full = 0;
      m_half = int'(fifo_level) >= DEPTH/2;
      if (!tc_clr_n) begin m_t = 0; m_pre = 0; end
      else if (!tc_run_n) begin
        if (m_pre + 1 >= per) begin m_pre = 0; m_t++; end
        else m_pre++;
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) if (rst_n && cmp_on) begin
    chk(fifo_wr == m_wr, "R2 R3 R4 R8 R9", "write strobe", fifo_wr, m_wr);
    if (m_wr) chk(fifo_wdata == m_word, "R1 R5", "fifo word", fifo_wdata, m_word);
    chk(time_now == m_t, "R6 R7", "time", time_now, m_t);
    chk(half_flag == m_half, "R10", "half flag", half_flag, m_half);
    chk(full_irq == m_full, "R10", "full flag", full_irq, m_full);
    chk(ovf_flag == m_ovf, "R8 R9", "overflow flag", ovf_flag, m_ovf);
  end

  task automatic send(input logic [15:0] a);
    ev_valid = 1'b1; ev_addr = a;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1; idle(1); irq_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    longint t0;
    idle(3);
    chk(fifo_wr == 0, "R11", "reset strobe", fifo_wr, 0);
    chk(time_now == 0, "R11", "reset time", time_now, 0);
    chk({half_flag, full_irq, ovf_flag} == 0, "R11", "reset flags",
        {half_flag, full_irq, ovf_flag}, 0);
    rst_n = 1'b1; cmp_on = 1'b1;
    idle(1); tc_run_n = 1'b0;

    // Timestamped records (R2, R5)
    idle(25); wcnt = 0;
    for (int i = 0; i < 4; i++) begin send(16'h1234 + 16'(i) * 16'h1111); idle(4 + i*7); end
    idle(4);
    chk(wcnt == 12, "R2", "timestamped word count", wcnt, 12);

    // Address-only back-to-back (R3)
    ts_dis = 1'b1; wcnt = 0;
    for (int i = 0; i < 6; i++) send(16'h0A00 + 16'(i));
    idle(4);
    chk(wcnt == 6, "R3", "address-only word count", wcnt, 6);

    // Acquisition disabled (R4)
    mon_dis = 1'b1; wcnt = 0;
    send(16'h0001); send(16'h8002); idle(4);
    chk(wcnt == 0, "R4", "words while disabled", wcnt, 0);
    chk(ovf_flag == 0, "R4", "no flag while disabled", ovf_flag, 0);
    mon_dis = 1'b0;

    // Channel masks in each sender mode (R4)
    arb_mode = 2'b10; ch_mask = 4'b0100; wcnt = 0;
    send(16'h8000); send(16'h4000); send(16'hC000); send(16'h0001); idle(4);
    chk(wcnt == 3, "R4", "four-sender mask", wcnt, 3);
    arb_mode = 2'b01; ch_mask = 4'b0010; wcnt = 0;
    send(16'h8000); send(16'h4000); send(16'hC000); idle(4);
    chk(wcnt == 1, "R4", "two-sender mask", wcnt, 1);
    arb_mode = 2'b00; ch_mask = 4'b0001; wcnt = 0;
    send(16'h8000); send(16'hC001); idle(4);
    chk(wcnt == 0, "R4", "one-sender mask all", wcnt, 0);
    ch_mask = 4'b1110; wcnt = 0;
    send(16'hC001); idle(4);
    chk(wcnt == 1, "R4", "one-sender channel 0", wcnt, 1);
    ch_mask = 4'b0000; arb_mode = 2'b10;

    // Busy drop (R9)
    ts_dis = 1'b0; wcnt = 0;
    send(16'h1111); send(16'h2222); send(16'h3333); idle(5);
    chk(wcnt == 3, "R9", "busy words", wcnt, 3);
    chk(ovf_flag == 1, "R9", "busy overflow", ovf_flag, 1);
    pulse_clr(); idle(1);
    chk(ovf_flag == 0, "R10", "overflow cleared", ovf_flag, 0);

    // Fill the FIFO (R8, R10)
    pop = 1'b0; wcnt = 0;
    for (int i = 0; i < 6; i++) begin send(16'h5000 + 16'(i)); idle(3); end
    idle(3);
    chk(wcnt == 15, "R8", "whole records only", wcnt, 15);
    chk(ovf_flag == 1, "R8", "no-room overflow", ovf_flag, 1);
    chk(half_flag == 1, "R10", "half flag", half_flag, 1);
    ts_dis = 1'b1; send(16'h6000); idle(3);
    chk(full_irq == 1, "R10", "full flag", full_irq, 1);
    send(16'h6001); idle(3);
    chk(wcnt == 16, "R8", "no write when full", wcnt, 16);
    pulse_clr(); idle(1);
    chk(full_irq == 1, "R10", "full stays while full", full_irq, 1);
    pop = 1'b1; idle(20); pulse_clr(); idle(2);
    chk({full_irq, ovf_flag, half_flag} == 0, "R10", "flags after drain",
        {full_irq, ovf_flag, half_flag}, 0);
    ts_dis = 1'b0;

    // Counter rates, hold and clear (R6, R7)
    tick_sel = 2'b00; idle(1); t0 = time_now; idle(5);
    chk(time_now == t0 + 5, "R6", "period 1", time_now, t0 + 5);
    tick_sel = 2'b01; t0 = time_now; idle(30);
    chk(time_now == t0 + 3, "R6", "period 10", time_now, t0 + 3);
    tick_sel = 2'b10; t0 = time_now; idle(150);
    chk(time_now == t0 + 3, "R6", "period 50", time_now, t0 + 3);
    tc_run_n = 1'b1; t0 = time_now; idle(120);
    chk(time_now == t0, "R6", "hold when stopped", time_now, t0);
    tc_clr_n = 1'b0; idle(1);
    chk(time_now == 0, "R7", "clear", time_now, 0);
    tick_sel = 2'b01; tc_clr_n = 1'b1; tc_run_n = 1'b0; idle(9);
    chk(time_now == 0, "R7", "restart before period", time_now, 0);
    idle(1);
    chk(time_now == 1, "R7", "restart after period", time_now, 1);
    tick_sel = 2'b11; t0 = time_now; idle(200);
    chk(time_now == t0 + 2, "R6", "period 100", time_now, t0 + 2);

    // Timestamped record with a non-zero time (R5)
    wcnt = 0; send(16'hBEEF); idle(4);
    chk(wcnt == 3, "R5", "late record words", wcnt, 3);
    idle(2);
    finish_run();
  end
endmodule